// File: doc/BRIEF.md
# Command-Sequenced I2C Bus Master

This block is the master side of an I2C controller that takes no bus action by itself. The host issues one short command per bus phase: start, repeated start, stop, receive one byte, or send an acknowledge bit. A write of a byte to the transmit input launches an eight-bit transfer plus the acknowledge clock. Each command occupies the block until its bus sequence ends. At that point the block drops its busy flag and raises a one-cycle completion pulse, so the host can issue the next phase.

Every SCL half-period comes from one reloadable down-counter that loads the host-supplied baud value. The block drives SCL and SDA only as open-drain pull-down enables and reads the resolved line levels back. This readback lets it see slave clock stretching, START and STOP conditions made by other masters, and loss of arbitration. It reports the acknowledge it received and holds the last byte it read.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset both pull-down enables are 0, busy, done, arbLost and wrColl are 0, busFree is 1, rxData is 0x00 and ackRecv is 0.
- R2: Every bus phase lasts baudReload+1 clock cycles when no stretching occurs. A start finishes with done high 2*(baudReload+1) cycles after the cycle that accepted the command.
- R3: A start is accepted only while the block is idle and busFree is 1. It pulls SDA low with SCL high for one phase, then pulls SCL low for one phase, and busFree drops. A start request while busFree is 0 has no effect.
- R4: A repeated start takes four phases: SDA released with SCL low, SCL released, SDA pulled low, SCL pulled low. It ends with both enables at 1.
- R5: A stop takes three phases: SDA low with SCL low, SCL released, SDA released. It ends with both enables at 0, and busFree returns to 1.
- R6: A transmit write sends txData MSB first over eight clocks, releases SDA for a ninth clock and stores the sampled level in ackRecv (0 = ACK, 1 = NACK). It takes 18 phases.
- R7: A receive command releases SDA for eight clocks, samples at the end of each high phase MSB first, and places the byte on rxData when it completes. It takes 16 phases.
- R8: An acknowledge command drives ackData for one clock: 0 pulls SDA low (ACK), 1 leaves it released (NACK).
- R9: busy is high from the cycle after acceptance until completion. done is a single-cycle pulse in the same cycle that busy falls.
- R10: A transmit write while busy, or in the same cycle as an accepted command, is discarded and produces a one-cycle wrColl pulse. The byte in flight is unchanged.
- R11: Commands issued while busy are ignored.
- R12: A high phase starts counting only once the SCL input reads high, so a slave holding SCL low lengthens the transfer by the held time.
- R13: If SDA reads low at the end of a high phase in which the master released it during the eight data bits of a transmit, the block pulses arbLost, releases both lines and returns to idle without a done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| baudReload | input | BAUD_W | Half-period reload value |
| cmdStart | input | 1 | Request start condition |
| cmdRestart | input | 1 | Request repeated start |
| cmdStop | input | 1 | Request stop condition |
| cmdRecv | input | 1 | Request reception of one byte |
| cmdAck | input | 1 | Request acknowledge clock |
| ackData | input | 1 | Level sent by the acknowledge command (1 = NACK) |
| txWrite | input | 1 | Write txData and launch a byte transmit |
| txData | input | 8 | Byte to transmit |
| sclIn | input | 1 | Resolved SCL level |
| sdaIn | input | 1 | Resolved SDA level |
| sclOe | output | 1 | Pull SCL low when 1 |
| sdaOe | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | A bus sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| arbLost | output | 1 | One-cycle arbitration-loss pulse |
| wrColl | output | 1 | One-cycle rejected-write pulse |
| ackRecv | output | 1 | Acknowledge level sampled after the last transmit |
| rxData | output | 8 | Last received byte |
| busFree | output | 1 | Both lines high since the last STOP |

## Verification
Two things can fall in one cycle. A transmit write can arrive in the same cycle as another accepted command, and it can also arrive while a sequence runs together with an ignored stop request. The bench raises txWrite with cmdStart on an idle bus, and it also raises txWrite with cmdStop in the middle of a byte transmit. In both cases it expects a wrColl pulse, an unaltered bus sequence of nominal length, and the original bits seen on SDA at each SCL rise. A slave model stretches SCL during a high phase, and a competing master holds SDA low, to test the timing gate and the arbitration exit.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_ST1, S_ST2, S_RS1, S_RS2, S_RS3, S_RS4,
    S_SP1, S_SP2, S_SP3, S_BLO, S_BHI
  } seqState_t;

  typedef enum logic [1:0] {M_TX, M_RX, M_ACK} bitMode_t;

  typedef struct packed {
    logic loadTx;
    logic sampleBit;
    logic latchRx;
    logic latchAck;
  } dpStrobe_t;
endpackage

// File: rtl/i2cm_datapath.sv
module i2cm_datapath
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [BYTE_W-1:0] txData,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              nextTxBit,
  output logic [BYTE_W-1:0] rxData,
  output logic              ackRecv,
  output logic              busFree
);
  logic [BYTE_W-1:0] shiftReg;
  logic sclPrev, sdaPrev;
  logic startSeen, stopSeen;

  assign nextTxBit = shiftReg[BYTE_W-2];
  assign startSeen = sclIn && sclPrev && sdaPrev && !sdaIn;
  assign stopSeen  = sclIn && sclPrev && !sdaPrev && sdaIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxData   <= '0;
      ackRecv  <= 1'b0;
    end else begin
      if (strobe.loadTx)
        shiftReg <= txData;
      else if (strobe.sampleBit)
        shiftReg <= {shiftReg[BYTE_W-2:0], sdaIn};
      if (strobe.latchRx)
        rxData <= {shiftReg[BYTE_W-2:0], sdaIn};
      if (strobe.latchAck)
        ackRecv <= sdaIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
      busFree <= 1'b1;
    end else begin
      sclPrev <= sclIn;
      sdaPrev <= sdaIn;
      if (startSeen)
        busFree <= 1'b0;
      else if (stopSeen)
        busFree <= 1'b1;
    end
  end

  // R7
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadTx, strobe.latchRx, strobe.latchAck}));

  // R7
  latch_needs_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latchRx || strobe.latchAck) |-> strobe.sampleBit);
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter int BAUD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BAUD_W-1:0] baudReload,
  input  logic              cmdStart,
  input  logic              cmdRestart,
  input  logic              cmdStop,
  input  logic              cmdRecv,
  input  logic              cmdAck,
  input  logic              ackData,
  input  logic              txWrite,
  input  logic              txFirstBit,
  input  logic              nextTxBit,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              busFree,
  output dpStrobe_t         strobe,
  output logic              sclOe,
  output logic              sdaOe,
  output logic              busy,
  output logic              done,
  output logic              arbLost,
  output logic              wrColl
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  seqState_t         state;
  bitMode_t          mode;
  logic [BAUD_W-1:0] cnt;
  logic [CNT_W-1:0]  bitCnt;
  logic sclLow, sdaLow;
  logic idle, waitHigh, gate, phaseEnd, bitEnd, lastBit, lost;
  logic startGo, rsGo, spGo, rxGo, ackGo, txGo, cmdTaken;

  assign sclOe = sclLow;
  assign sdaOe = sdaLow;
  assign idle  = (state == S_IDLE);
  assign busy  = !idle;

  always_comb begin
    waitHigh = (state == S_RS2) || (state == S_SP2) || (state == S_BHI);
    gate     = !waitHigh || sclIn;
    phaseEnd = !idle && gate && (cnt == '0);
    startGo  = idle && cmdStart && busFree;
    rsGo     = idle && !startGo && cmdRestart;
    spGo     = idle && !startGo && !cmdRestart && cmdStop;
    rxGo     = idle && !startGo && !cmdRestart && !cmdStop && cmdRecv;
    ackGo    = idle && !startGo && !cmdRestart && !cmdStop && !cmdRecv && cmdAck;
    cmdTaken = startGo || rsGo || spGo || rxGo || ackGo;
    txGo     = idle && txWrite && !cmdTaken;
    bitEnd   = (state == S_BHI) && phaseEnd;
    lastBit  = ((mode == M_TX) && (bitCnt == CNT_W'(BYTE_W))) ||
               ((mode == M_RX) && (bitCnt == CNT_W'(BYTE_W - 1))) ||
               (mode == M_ACK);
    lost     = bitEnd && (mode == M_TX) && (bitCnt < CNT_W'(BYTE_W)) &&
               !sdaLow && !sdaIn;
    strobe.loadTx    = txGo;
    strobe.sampleBit = bitEnd;
    strobe.latchRx   = bitEnd && lastBit && (mode == M_RX);
    strobe.latchAck  = bitEnd && lastBit && (mode == M_TX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      mode    <= M_TX;
      cnt     <= '0;
      bitCnt  <= '0;
      sclLow  <= 1'b0;
      sdaLow  <= 1'b0;
      done    <= 1'b0;
      arbLost <= 1'b0;
      wrColl  <= 1'b0;
    end else begin
      done    <= 1'b0;
      arbLost <= 1'b0;
      wrColl  <= txWrite && !txGo;
      if (idle) begin
        cnt    <= baudReload;
        bitCnt <= '0;
        if (startGo) begin
          state <= S_ST1; sdaLow <= 1'b1;
        end else if (rsGo) begin
          state <= S_RS1; sdaLow <= 1'b0;
        end else if (spGo) begin
          state <= S_SP1; sdaLow <= 1'b1; sclLow <= 1'b1;
        end else if (rxGo) begin
          state <= S_BLO; mode <= M_RX; sclLow <= 1'b1; sdaLow <= 1'b0;
        end else if (ackGo) begin
          state <= S_BLO; mode <= M_ACK; sclLow <= 1'b1; sdaLow <= !ackData;
        end else if (txGo) begin
          state <= S_BLO; mode <= M_TX; sclLow <= 1'b1; sdaLow <= !txFirstBit;
        end
      end else if (!phaseEnd) begin
        if (gate) cnt <= cnt - BAUD_W'(1);
      end else begin
        cnt <= baudReload;
        case (state)
          S_ST1: begin state <= S_ST2; sclLow <= 1'b1; end
          S_ST2: begin state <= S_IDLE; done <= 1'b1; end
          S_RS1: begin state <= S_RS2; sclLow <= 1'b0; end
          S_RS2: begin state <= S_RS3; sdaLow <= 1'b1; end
          S_RS3: begin state <= S_RS4; sclLow <= 1'b1; end
          S_RS4: begin state <= S_IDLE; done <= 1'b1; end
          S_SP1: begin state <= S_SP2; sclLow <= 1'b0; end
          S_SP2: begin state <= S_SP3; sdaLow <= 1'b0; end
          S_SP3: begin state <= S_IDLE; done <= 1'b1; end
          S_BLO: begin state <= S_BHI; sclLow <= 1'b0; end
          S_BHI: begin
            if (lost) begin
              state <= S_IDLE; arbLost <= 1'b1; sclLow <= 1'b0; sdaLow <= 1'b0;
            end else if (lastBit) begin
              state <= S_IDLE; done <= 1'b1; sclLow <= 1'b1;
            end else begin
              state  <= S_BLO;
              sclLow <= 1'b1;
              bitCnt <= bitCnt + CNT_W'(1);
              if ((mode == M_TX) && (bitCnt < CNT_W'(BYTE_W - 1)))
                sdaLow <= !nextTxBit;
              else
                sdaLow <= 1'b0;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R9
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done || arbLost));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R13
  arb_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    arbLost |-> (!sclOe && !sdaOe && !done));

  // R10
  wr_coll_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txWrite && busy) |=> wrColl);

  // R12
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == S_BHI) && !sclIn) |=> (cnt == $past(cnt)));

  // R3
  start_refused_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idle && cmdStart && !busFree && !cmdRestart && !cmdStop && !cmdRecv &&
     !cmdAck && !txWrite) |=> !busy);
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2cm_pkg::*;
#(
  parameter int BAUD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BAUD_W-1:0] baudReload,
  input  logic              cmdStart,
  input  logic              cmdRestart,
  input  logic              cmdStop,
  input  logic              cmdRecv,
  input  logic              cmdAck,
  input  logic              ackData,
  input  logic              txWrite,
  input  logic [7:0]        txData,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  output logic              busy,
  output logic              done,
  output logic              arbLost,
  output logic              wrColl,
  output logic              ackRecv,
  output logic [7:0]        rxData,
  output logic              busFree
);
  dpStrobe_t strobe;
  logic      nextTxBit;

  i2cm_ctrl #(.BAUD_W(BAUD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .baudReload(baudReload),
    .cmdStart(cmdStart), .cmdRestart(cmdRestart), .cmdStop(cmdStop),
    .cmdRecv(cmdRecv), .cmdAck(cmdAck), .ackData(ackData),
    .txWrite(txWrite), .txFirstBit(txData[BYTE_W-1]), .nextTxBit(nextTxBit),
    .sclIn(sclIn), .sdaIn(sdaIn), .busFree(busFree), .strobe(strobe),
    .sclOe(sclOe), .sdaOe(sdaOe), .busy(busy), .done(done),
    .arbLost(arbLost), .wrColl(wrColl)
  );

  i2cm_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txData(txData),
    .sclIn(sclIn), .sdaIn(sdaIn), .nextTxBit(nextTxBit),
    .rxData(rxData), .ackRecv(ackRecv), .busFree(busFree)
  );
endmodule

// File: tb/tb_i2c_cmd_master.sv
`timescale 1ns/1ps
module tb_i2c_cmd_master;
  localparam int B = 3;
  localparam int PH = B + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdStart = 0, cmdRestart = 0, cmdStop = 0, cmdRecv = 0, cmdAck = 0;
  logic ackData = 0, txWrite = 0;
  logic [7:0] txData = 8'h00;
  logic slvScl = 0, slvSda = 0;
  logic sclOe, sdaOe, busy, done, arbLost, wrColl, ackRecv, busFree;
  logic [7:0] rxData;
  wire sclLine = !sclOe && !slvScl;
  wire sdaLine = !sdaOe && !slvSda;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  i2c_cmd_master #(.BAUD_W(8)) dut (
    .clk(clk), .rstN(rstN), .baudReload(8'(B)),
    .cmdStart(cmdStart), .cmdRestart(cmdRestart), .cmdStop(cmdStop),
    .cmdRecv(cmdRecv), .cmdAck(cmdAck), .ackData(ackData),
    .txWrite(txWrite), .txData(txData), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclOe(sclOe), .sdaOe(sdaOe), .busy(busy), .done(done),
    .arbLost(arbLost), .wrColl(wrColl), .ackRecv(ackRecv),
    .rxData(rxData), .busFree(busFree)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearCmds();
    cmdStart = 0; cmdRestart = 0; cmdStop = 0; cmdRecv = 0; cmdAck = 0; txWrite = 0;
  endtask

  // which: 0 start, 1 restart, 2 stop
  task automatic runCmd(input int which, input int limit, input bit withTx,
                        output int n, output bit busy1, output bit col1);
    @(negedge clk);
    if (which == 0) cmdStart = 1; else if (which == 1) cmdRestart = 1; else cmdStop = 1;
    if (withTx) begin txWrite = 1; txData = 8'h11; end
    n = 0; busy1 = 0; col1 = 0;
    while (n < limit) begin
      @(posedge clk); n++;
      @(negedge clk);
      clearCmds();
      if (n == 1) begin busy1 = busy; col1 = wrColl; end
      if (done || arbLost) break;
    end
  endtask

  task automatic runTx(input logic [7:0] b, input bit nack, input int hold,
                       input bit fight, input bit inject, output int n,
                       output logic [7:0] seen, output bit lost, output bit col);
    int rises = 0, falls = 0;
    bit prevScl;
    @(negedge clk);
    txData = b; txWrite = 1;
    if (hold > 0) slvScl = 1;
    if (fight) slvSda = 1;
    n = 0; seen = 8'h00; lost = 0; col = 0; prevScl = sclLine;
    while (n < 3000) begin
      @(posedge clk); n++;
      @(negedge clk);
      clearCmds();
      if (wrColl) col = 1;
      if (inject && n == 10) begin txWrite = 1; txData = 8'hFF; cmdStop = 1; end
      if (hold > 0 && n == hold) slvScl = 0;
      if (sclLine && !prevScl) begin
        if (rises < 8) seen = {seen[6:0], sdaLine};
        rises++;
      end
      if (!sclLine && prevScl) begin
        falls++;
        if (falls == 8) slvSda = !nack;
        if (falls == 9) slvSda = 0;
      end
      prevScl = sclLine;
      if (done) break;
      if (arbLost) begin lost = 1; break; end
    end
    if (!fight) slvSda = 0;
  endtask

  task automatic runRx(input logic [7:0] b, output int n);
    int falls = 0;
    bit prevScl;
    @(negedge clk);
    slvSda = !b[7]; cmdRecv = 1;
    n = 0; prevScl = sclLine;
    while (n < 3000) begin
      @(posedge clk); n++;
      @(negedge clk);
      clearCmds();
      if (!sclLine && prevScl) begin
        falls++;
        if (falls < 8) slvSda = !b[7 - falls];
      end
      prevScl = sclLine;
      if (done) break;
    end
    slvSda = 0;
  endtask

  task automatic runAck(input bit a, output int n, output bit lvl);
    bit prevScl;
    @(negedge clk);
    ackData = a; cmdAck = 1;
    n = 0; lvl = 0; prevScl = sclLine;
    while (n < 500) begin
      @(posedge clk); n++;
      @(negedge clk);
      clearCmds();
      if (sclLine && !prevScl) lvl = sdaLine;
      prevScl = sclLine;
      if (done) break;
    end
  endtask

  task automatic testReset();
    chk(!sclOe && !sdaOe, "R1 lines released", {sclOe, sdaOe}, 0);
    chk(!busy && !done && !arbLost && !wrColl, "R1 flags", {busy, done, arbLost, wrColl}, 0);
    chk(busFree == 1, "R1 busFree", busFree, 1);
    chk(rxData == 8'h00 && ackRecv == 0, "R1 rx state", {ackRecv, rxData}, 0);
  endtask

  task automatic testStart();
    int n; bit b1, c1;
    runCmd(0, 200, 0, n, b1, c1);
    chk(n == 2 * PH + 1, "R2 start length", n, 2 * PH + 1);
    chk(b1 == 1, "R9 busy during start", b1, 1);
    chk(sclOe && sdaOe, "R3 lines held low after start", {sclOe, sdaOe}, 3);
    chk(busFree == 0, "R3 busFree cleared", busFree, 0);
    @(negedge clk);
    chk(done == 0, "R9 done is one cycle", done, 0);
  endtask

  task automatic testStartRefused();
    int n; bit b1, c1;
    runCmd(0, 20, 0, n, b1, c1);
    chk(n == 20 && !done, "R3 start refused on busy bus", n, 20);
    chk(b1 == 0, "R3 no busy on refused start", b1, 0);
    chk(sclOe && sdaOe, "R3 lines unchanged", {sclOe, sdaOe}, 3);
  endtask

  task automatic testTxAck();
    int n; logic [7:0] s; bit l, c;
    runTx(8'hA5, 0, 0, 0, 0, n, s, l, c);
    chk(s == 8'hA5, "R6 bits MSB first", s, 8'hA5);
    chk(n == 18 * PH + 1, "R6 transmit length", n, 18 * PH + 1);
    chk(ackRecv == 0, "R6 ACK received", ackRecv, 0);
  endtask

  task automatic testTxCollide();
    int n; logic [7:0] s; bit l, c;
    runTx(8'h3C, 1, 0, 0, 1, n, s, l, c);
    chk(c == 1, "R10 wrColl on busy write", c, 1);
    chk(s == 8'h3C, "R10 byte unaltered", s, 8'h3C);
    chk(n == 18 * PH + 1, "R11 stop ignored while busy", n, 18 * PH + 1);
    chk(ackRecv == 1, "R6 NACK received", ackRecv, 1);
  endtask

  task automatic testRestart();
    int n; bit b1, c1;
    runCmd(1, 200, 0, n, b1, c1);
    chk(n == 4 * PH + 1, "R4 restart length", n, 4 * PH + 1);
    chk(sclOe && sdaOe, "R4 lines after restart", {sclOe, sdaOe}, 3);
    chk(busFree == 0, "R4 bus stays owned", busFree, 0);
  endtask

  task automatic testRxAck();
    int n; bit lvl;
    runRx(8'h96, n);
    chk(rxData == 8'h96, "R7 received byte", rxData, 8'h96);
    chk(n == 16 * PH + 1, "R7 receive length", n, 16 * PH + 1);
    runAck(0, n, lvl);
    chk(lvl == 0, "R8 ACK drives SDA low", lvl, 0);
    chk(n == 2 * PH + 1, "R8 acknowledge length", n, 2 * PH + 1);
    runRx(8'h41, n);
    chk(rxData == 8'h41, "R7 second byte", rxData, 8'h41);
    runAck(1, n, lvl);
    chk(lvl == 1, "R8 NACK releases SDA", lvl, 1);
  endtask

  task automatic testStretch();
    int n; logic [7:0] s; bit l, c;
    runTx(8'h5A, 0, 40, 0, 0, n, s, l, c);
    chk(n >= 104 && n <= 112, "R12 stretched length", n, 108);
    chk(s == 8'h5A, "R12 data under stretch", s, 8'h5A);
  endtask

  task automatic testStop();
    int n; bit b1, c1;
    runCmd(2, 200, 0, n, b1, c1);
    chk(n == 3 * PH + 1, "R5 stop length", n, 3 * PH + 1);
    chk(!sclOe && !sdaOe, "R5 lines released", {sclOe, sdaOe}, 0);
    chk(busFree == 1, "R5 busFree set", busFree, 1);
  endtask

  task automatic testSameCycle();
    int n; bit b1, c1;
    runCmd(0, 200, 1, n, b1, c1);
    chk(c1 == 1, "R10 write with command collides", c1, 1);
    chk(n == 2 * PH + 1, "R10 start unaffected", n, 2 * PH + 1);
  endtask

  task automatic testArb();
    int n; logic [7:0] s; bit l, c;
    runTx(8'h80, 0, 0, 1, 0, n, s, l, c);
    chk(l == 1, "R13 arbitration lost", l, 1);
    chk(!sclOe && !sdaOe && !busy, "R13 released and idle", {sclOe, sdaOe, busy}, 0);
    @(negedge clk);
    slvSda = 0;
    repeat (3) @(negedge clk);
    chk(busFree == 1, "R13 bus free after other stop", busFree, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    repeat (2) @(negedge clk);
    testStart();
    testStartRefused();
    testTxAck();
    testTxCollide();
    testRestart();
    testRxAck();
    testStretch();
    testStop();
    testSameCycle();
    testArb();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule